// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's complement operands of `WIDTH` bits and returns their full `2*WIDTH`-bit signed product. It handles two multiplier bits per clock by recoding each overlapping group of three multiplier bits into a signed digit from −2 to +2. A `WIDTH`-bit multiply therefore takes `WIDTH/2` iterations. Negative operands need no pre- or post-processing.

The caller presents both operands together with a one-cycle `start` pulse while the block is idle. The block raises `busy` and works through the digits, least significant first. On each digit it adds or subtracts once or twice the multiplicand into the upper part of its product register. It then shifts the whole register right by two places, keeping the sign. When the last digit is done it drops `busy` and pulses `done`. The result stays on `product` until the next accepted start.

Top module: `booth4_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` seen at a rising edge while `busy` is 0 captures `mcand` and `mplier`, and `busy` is 1 from that edge on.
- R3: The digit for step i comes from the bits {b(2i+1), b(2i), b(2i−1)} of the multiplier, with b(−1) taken as 0. The triples 000 and 111 select 0. The triples 001 and 010 select +1. The triple 011 selects +2. The triple 100 selects −2. The triples 101 and 110 select −1. When `done` is 1, `product` equals the signed product of the captured operands, for example 0xFA × 0x06 = 0xFFDC (−6 × 6 = −36) and 0xFA × 0xFE = 0x000C.
- R4: `done` goes to 1 exactly `WIDTH/2` rising edges after the edge that accepted `start`. It stays 1 for one cycle only, and `busy` is 0 while `done` is 1.
- R5: A `start` pulse while `busy` is 1 is ignored. It changes neither the result nor the timing of the operation in progress.
- R6: While the block is idle and `start` is 0, `product` holds its value, even when the operand inputs change.
- R7: The accumulator never overflows. The most negative operand times itself gives +2^(2·WIDTH−2), which is 0x4000 for `WIDTH` = 8.
- R8: A `start` presented in the cycle where `done` is 1 is accepted, and a new operation begins at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiply; honoured only when idle |
| mcand | input | WIDTH | Multiplicand, signed |
| mplier | input | WIDTH | Multiplier, signed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when `product` is final |
| product | output | 2*WIDTH | Signed product |

## Verification
The hardest case to reach from the ports is a `start` that arrives while an operation is in progress. To be a real test, it must carry different operands, and it must land mid-iteration. The bench launches one multiply and pulses `start` two cycles later with 0x7F × 0x7F. It then checks that `done` still arrives on the original schedule and carries the first operands' product. The operand table also places the most negative operand on both sides, to stress the widened accumulator. It includes alternating-bit patterns, so that every recoded digit value occurs.

// File: rtl/booth4_mul.sv
module booth4_mul #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  localparam int STEPS = WIDTH / 2;
  localparam int CW    = $clog2(STEPS + 1);
  localparam int AW    = WIDTH + 2;

  logic signed [AW-1:0] hi, m_ext, addend, sum;
  logic [WIDTH-1:0]     lo, m_reg;
  logic                 q;
  logic [CW-1:0]        cnt;
  logic [2:0]           trip;

  assign trip  = {lo[1], lo[0], q};
  assign m_ext = {{2{m_reg[WIDTH-1]}}, m_reg};

  always_comb begin
    case (trip)
      3'b001, 3'b010: addend = m_ext;
      3'b011:         addend = m_ext <<< 1;
      3'b100:         addend = -(m_ext <<< 1);
      3'b101, 3'b110: addend = -m_ext;
      default:        addend = '0;
    endcase
  end

  assign sum     = hi + addend;
  assign product = {hi[WIDTH-1:0], lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi    <= '0;
      lo    <= '0;
      q     <= 1'b0;
      m_reg <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          hi    <= '0;
          lo    <= mplier;
          q     <= 1'b0;
          m_reg <= mcand;
          cnt   <= '0;
          busy  <= 1'b1;
        end
      end else begin
        hi  <= sum >>> 2;
        lo  <= {sum[1:0], lo[WIDTH-1:2]};
        q   <= lo[1];
        cnt <= cnt + 1'b1;
        if (cnt == CW'(STEPS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/booth4_mul_chk.sv
module booth4_mul_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [WIDTH-1:0]   mcand,
  input logic [WIDTH-1:0]   mplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  localparam int STEPS = WIDTH / 2;
  localparam int CW    = $clog2(STEPS + 2);

  logic signed [WIDTH-1:0] cap_a, cap_b;
  logic [CW-1:0]           cyc;
  logic signed [2*WIDTH-1:0] expect_p;
  logic                    both_min;

  assign expect_p = (2*WIDTH)'(cap_a) * (2*WIDTH)'(cap_b);
  assign both_min = (cap_a == {1'b1, {(WIDTH-1){1'b0}}}) && (cap_b == {1'b1, {(WIDTH-1){1'b0}}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
      cyc   <= '0;
    end else if (start && !busy) begin
      cap_a <= mcand;
      cap_b <= mplier;
      cyc   <= '0;
    end else if (busy) begin
      cyc <= cyc + 1'b1;
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == expect_p));
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cyc == CW'(STEPS)));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && both_min) |-> (product == {2'b01, {(2*WIDTH-2){1'b0}}}));
endmodule

bind booth4_mul booth4_mul_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
  .busy(busy), .done(done), .product(product)
);

// File: tb/booth4_mul_tb_top.sv
module booth4_mul_tb_top;
  localparam int W     = 8;
  localparam int STEPS = W / 2;
  localparam int NV    = 10;

  localparam logic [4*W-1:0] VEC [NV] = '{
    {8'hFA, 8'h06, 16'hFFDC},
    {8'hFA, 8'hFE, 16'h000C},
    {8'h00, 8'h05, 16'h0000},
    {8'h7F, 8'h7F, 16'h3F01},
    {8'h80, 8'h80, 16'h4000},
    {8'h80, 8'h7F, 16'hC080},
    {8'h01, 8'hFF, 16'hFFFF},
    {8'h55, 8'hAA, 16'hE372},
    {8'h03, 8'h07, 16'h0015},
    {8'hFF, 8'hFF, 16'h0001}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0, mplier = '0;
  logic           busy, done;
  logic [2*W-1:0] product;
  int             checks = 0, errors = 0;
  bit             finished = 1'b0;

  always #4 clk = ~clk;

  booth4_mul #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
    mcand = a; mplier = b; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", {31'd0, busy}, 32'd1);
  endtask

  task automatic await_done(input logic [2*W-1:0] exp, input string req);
    for (int k = 1; k <= STEPS; k++) begin
      @(posedge clk); #1;
      if (k < STEPS && done) chk(1'b0, "R4 early done", k, STEPS);
    end
    chk(done == 1'b1 && busy == 1'b0, "R4 done timing", {30'd0, done, busy}, 32'd2);
    chk(product == exp, req, {16'd0, product}, {16'd0, exp});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 0 && done == 0 && product == 0, "R1 reset state", {15'd0, busy, product}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(busy == 0 && done == 0 && product == 0, "R1 after reset", {15'd0, busy, product}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      launch(VEC[i][4*W-1:3*W], VEC[i][3*W-1:2*W]);
      await_done(VEC[i][2*W-1:0], (VEC[i][4*W-1:2*W] == 16'h8080) ? "R7 min times min" : "R3 product");
      @(posedge clk); #1;
      chk(done == 1'b0, "R4 one-cycle done", {31'd0, done}, 32'd0);
    end

    // R5: start mid-operation with other operands is ignored
    launch(8'h13, 8'hF9);
    @(posedge clk); #1;
    mcand = 8'h7F; mplier = 8'h7F; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 3; k <= STEPS; k++) begin
      @(posedge clk); #1;
      if (k < STEPS && done) chk(1'b0, "R5 early done", k, STEPS);
    end
    chk(done == 1'b1, "R5 done on schedule", {31'd0, done}, 32'd1);
    chk(product == 16'hFF7B, "R5 ignored start", {16'd0, product}, 32'hFF7B);

    // R6: idle hold with changing inputs
    for (int k = 0; k < 5; k++) begin
      mcand = 8'(k * 37); mplier = 8'(k * 91);
      @(posedge clk); #1;
    end
    chk(product == 16'hFF7B, "R6 product held", {16'd0, product}, 32'hFF7B);

    // R8: back-to-back start in the done cycle
    launch(8'hFC, 8'h09);
    await_done(16'hFFDC, "R3 product");
    launch(8'h05, 8'hFD);
    await_done(16'hFFF1, "R8 back-to-back");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule